// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is the output stage of a small programmable-logic fabric. It has one or more parallel cells. Each cell receives a sum term from the array and shapes it into a pin drive. The cell either holds the sum term in a D flip-flop or passes it straight through. It can then invert the value or keep it true, and it gates the result with its own output-enable term. Every cell also returns one feedback bit to the array. All cells share the clock, an asynchronous clear term, a synchronous set term and a test preload strobe.

The pin is modelled as three signals: a drive value, a drive enable, and a separate pin-input port that carries whatever an outside source places on the pin.

- A registered cell is an output only. Its feedback is the inverted flip-flop state.
- A combinatorial cell feeds back the pin as seen after the enable buffer. When its driver is off, it can therefore read an external value.

The clear and set terms act on the flip-flop state, before the inversion stage. A cleared register therefore shows as high at an inverting pin and as low at a true pin. The power-up reset and the preload path let a test sequence start the register from a known state, or from any state it chooses.

Top module: `olmc_cell`

## Requirements
- R1: Two configuration bits per cell set its behaviour. `cfg_comb`=0 selects registered mode and `cfg_comb`=1 selects combinatorial mode. `cfg_pol`=1 drives the pin true (active high) and `cfg_pol`=0 drives it inverted (active low).
- R2: In combinatorial mode `pin_out` equals the sum term when `cfg_pol`=1 and its complement when `cfg_pol`=0. It follows the sum term with no clock.
- R3: In registered mode the flip-flop captures the sum term on each rising clock edge when no clear, set or preload applies. `pin_out` is the flip-flop state, passed through the polarity stage of R2.
- R4: `pin_oe` follows the cell's output-enable term in both modes.
- R5: While `ar_term` is 1, every register holds 0 at once, without waiting for a clock edge. This clear overrides reset, set, preload and capture.
- R6: When `sp_term` is 1 at a rising edge (and `ar_term` is 0), every register becomes 1. The set overrides preload and capture.
- R7: Clear and set act on the flip-flop state, whatever the polarity. A cleared register drives `pin_out`=1 when `cfg_pol`=0 and `pin_out`=0 when `cfg_pol`=1.
- R8: In registered mode, `fb` is the complement of the flip-flop state, and `pin_in` has no effect on it.
- R9: In combinatorial mode, `fb` equals `pin_out` while `oe_term` is 1 and equals `pin_in` while `oe_term` is 0.
- R10: `rst_n` is a synchronous active-low reset. A rising edge with `rst_n`=0 sets every register to 0. Before that edge the state is unchanged.
- R11: When `pl_en` is 1 at a rising edge, with neither clear nor set active, each register loads its `pl_val` bit instead of the sum term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| sum_term | input | LANES | Sum term per cell |
| oe_term | input | LANES | Output-enable term per cell |
| ar_term | input | 1 | Shared asynchronous clear term, active high |
| sp_term | input | 1 | Shared synchronous set term, active high |
| pl_en | input | 1 | Preload strobe |
| pl_val | input | LANES | Preload value per cell |
| cfg_pol | input | LANES | Polarity bit per cell, 1 = true |
| cfg_comb | input | LANES | Mode bit per cell, 1 = combinatorial |
| pin_in | input | LANES | Value seen on the pin from outside |
| pin_out | output | LANES | Pin drive value |
| pin_oe | output | LANES | Pin drive enable |
| fb | output | LANES | Feedback bit to the array |

## Verification
Some relations are checked on every cycle:
- the two feedback paths against the pin and the pin input;
- the combinatorial path through the polarity stage;
- the immediate effect of the clear term on both the feedback and the pin;
- the next-edge effect of the set term, of preload, of ordinary capture and of the synchronous reset.

Other behaviours only the bench's scenarios show:
- the priority order when clear, set and preload coincide;
- that the synchronous reset leaves the state alone until the edge;
- that the outputs stay right across mode and polarity changes made while running.

The bench's behavioural model is compared on every cycle against all three outputs, so it also shows that pin-input activity cannot reach a registered cell's feedback.

// File: rtl/olmc_pkg.sv
// Package: shared types for the output logic macrocell.
// Assumes single-bit configuration fields per cell.
package olmc_pkg;
    // Source that drives the polarity stage.
    typedef enum logic {
        SRC_REG  = 1'b0,
        SRC_COMB = 1'b1
    } src_sel_e;

    // Polarity choice at the pin.
    typedef enum logic {
        POL_INV  = 1'b0,
        POL_TRUE = 1'b1
    } pol_sel_e;
endpackage

// File: rtl/olmc_storage.sv
// Module: olmc_storage
// The D flip-flop of one cell.
// Priority: asynchronous clear > synchronous reset > synchronous set > preload > capture.
// Assumes clr_async is a glitch-free term from the array.
module olmc_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_async,
    input  logic set_sync,
    input  logic load_en,
    input  logic load_val,
    input  logic d,
    output logic q
);
    // State update: the clear acts at once, everything else acts on the clock edge.
    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            q <= 1'b0;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (set_sync) begin
            q <= 1'b1;
        end else if (load_en) begin
            q <= load_val;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/olmc_drive.sv
// Module: olmc_drive
// Picks the register or the sum term as the source, applies polarity, and passes the enable.
// Assumes the enable is already a resolved product term.
module olmc_drive
    import olmc_pkg::*;
(
    input  src_sel_e src_sel,
    input  pol_sel_e pol_sel,
    input  logic     reg_q,
    input  logic     sum_in,
    input  logic     en_in,
    output logic     drv_val,
    output logic     drv_en
);
    logic src_bit;

    // Source mux followed by the polarity stage.
    always_comb begin
        src_bit = (src_sel == SRC_COMB) ? sum_in : reg_q;
        drv_val = (pol_sel == POL_TRUE) ? src_bit : ~src_bit;
        drv_en  = en_in;
    end
endmodule

// File: rtl/olmc_return.sv
// Module: olmc_return
// Selects the feedback bit returned to the array.
// Registered mode returns the inverted register; combinatorial mode returns the resolved pin.
// Assumes the pin resolves to the driven value whenever the driver is on.
module olmc_return
    import olmc_pkg::*;
(
    input  src_sel_e src_sel,
    input  logic     reg_q,
    input  logic     drv_val,
    input  logic     drv_en,
    input  logic     ext_in,
    output logic     fb_out
);
    logic pin_seen;

    // Resolve the pin, then choose the feedback source.
    always_comb begin
        pin_seen = drv_en ? drv_val : ext_in;
        fb_out   = (src_sel == SRC_COMB) ? pin_seen : ~reg_q;
    end
endmodule

// File: rtl/olmc_cell.sv
// Module: olmc_cell (top)
// LANES parallel output macrocells.
// Shared among all cells: clock, reset, clear, set and preload strobe.
// Per cell: mode, polarity, sum, enable, preload value and pin input.
// Assumes every input is synchronous to clk except ar_term.
module olmc_cell
    import olmc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sum_term,
    input  logic [LANES-1:0] oe_term,
    input  logic             ar_term,
    input  logic             sp_term,
    input  logic             pl_en,
    input  logic [LANES-1:0] pl_val,
    input  logic [LANES-1:0] cfg_pol,
    input  logic [LANES-1:0] cfg_comb,
    input  logic [LANES-1:0] pin_in,
    output logic [LANES-1:0] pin_out,
    output logic [LANES-1:0] pin_oe,
    output logic [LANES-1:0] fb
);
    localparam int LAST = LANES - 1;

    logic [LAST:0] q_bits;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        src_sel_e src_sel;
        pol_sel_e pol_sel;

        // Map the raw configuration bits onto the package types.
        always_comb begin
            src_sel = src_sel_e'(cfg_comb[g]);
            pol_sel = pol_sel_e'(cfg_pol[g]);
        end

        olmc_storage u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_async(ar_term),
            .set_sync (sp_term),
            .load_en  (pl_en),
            .load_val (pl_val[g]),
            .d        (sum_term[g]),
            .q        (q_bits[g])
        );

        olmc_drive u_drive (
            .src_sel(src_sel),
            .pol_sel(pol_sel),
            .reg_q  (q_bits[g]),
            .sum_in (sum_term[g]),
            .en_in  (oe_term[g]),
            .drv_val(pin_out[g]),
            .drv_en (pin_oe[g])
        );

        olmc_return u_ret (
            .src_sel(src_sel),
            .reg_q  (q_bits[g]),
            .drv_val(pin_out[g]),
            .drv_en (pin_oe[g]),
            .ext_in (pin_in[g]),
            .fb_out (fb[g])
        );
    end
endmodule

// File: rtl/olmc_cell_chk.sv
// Module: olmc_cell_chk
// Property checker for olmc_cell, attached through bind.
// Observes only the ports of the top module.
module olmc_cell_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] sum_term,
    input logic [LANES-1:0] oe_term,
    input logic             ar_term,
    input logic             sp_term,
    input logic             pl_en,
    input logic [LANES-1:0] pl_val,
    input logic [LANES-1:0] cfg_pol,
    input logic [LANES-1:0] cfg_comb,
    input logic [LANES-1:0] pin_in,
    input logic [LANES-1:0] pin_out,
    input logic [LANES-1:0] pin_oe,
    input logic [LANES-1:0] fb
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_comb[g] && oe_term[g] |-> fb[g] == pin_out[g] && pin_out[g] == (cfg_pol[g] ? sum_term[g] : !sum_term[g])); // R2
        AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || ar_term)
            !sp_term && !pl_en && !cfg_comb[g] |=> cfg_comb[g] || fb[g] == !$past(sum_term[g])); // R3
        AST_CLEAR_FB: assert property (@(posedge clk) disable iff (!rst_n)
            ar_term && !cfg_comb[g] |-> fb[g] == 1'b1); // R5
        AST_SET_NEXT: assert property (@(posedge clk) disable iff (!rst_n || ar_term)
            sp_term && !cfg_comb[g] |=> cfg_comb[g] || fb[g] == 1'b0); // R6
        AST_CLEAR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            ar_term && !cfg_comb[g] |-> pin_out[g] == !cfg_pol[g]); // R7
        AST_REG_FB: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_comb[g] |-> fb[g] == (cfg_pol[g] ? !pin_out[g] : pin_out[g])); // R8
        AST_COMB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_comb[g] && !oe_term[g] |-> fb[g] == pin_in[g]); // R9
        AST_SYNC_RESET: assert property (@(posedge clk) disable iff (ar_term)
            !rst_n && !cfg_comb[g] |=> cfg_comb[g] || fb[g] == 1'b1); // R10
        AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n || ar_term)
            pl_en && !sp_term && !cfg_comb[g] |=> cfg_comb[g] || fb[g] == !$past(pl_val[g])); // R11
    end
endmodule

bind olmc_cell olmc_cell_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/olmc_cell_tb_top.sv
// Bench: a behavioural per-lane model, compared with every output on every cycle.
module olmc_cell_tb_top;
    localparam int LANES = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic [LANES-1:0] sum_term, oe_term, pl_val, cfg_pol, cfg_comb, pin_in;
    logic             ar_term, sp_term, pl_en;
    logic [LANES-1:0] pin_out, pin_oe, fb;

    olmc_cell #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
        .ar_term(ar_term), .sp_term(sp_term), .pl_en(pl_en), .pl_val(pl_val),
        .cfg_pol(cfg_pol), .cfg_comb(cfg_comb), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int mq [LANES];

    // Reference state, kept as integers.
    always @(posedge clk or posedge ar_term) begin
        for (int l = 0; l < LANES; l++) begin
            if (ar_term)        mq[l] = 0;
            else if (!rst_n)    mq[l] = 0;
            else if (sp_term)   mq[l] = 1;
            else if (pl_en)     mq[l] = int'(pl_val[l]);
            else                mq[l] = int'(sum_term[l]);
        end
    end

    task automatic one(string tag, int l, string what, logic act, int exp);
        checks++;
        if (act !== logic'(exp[0])) begin
            fails++;
            $display("FAIL %s lane %0d %s actual=%0b expected=%0d", tag, l, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        for (int l = 0; l < LANES; l++) begin
            int eq, src, po, ef;
            eq  = ar_term ? 0 : mq[l];
            src = cfg_comb[l] ? int'(sum_term[l]) : eq;
            po  = cfg_pol[l] ? src : 1 - src;
            ef  = cfg_comb[l] ? (oe_term[l] ? po : int'(pin_in[l])) : 1 - eq;
            one(tag, l, "pin_out", pin_out[l], po);
            one(tag, l, "pin_oe", pin_oe[l], int'(oe_term[l]));
            one(tag, l, "fb", fb[l], ef);
        end
    endtask

    // Compare just after the inputs change, then move to the next falling edge.
    task automatic cyc(string tag);
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; ar_term = 0; sp_term = 0; pl_en = 0;
        sum_term = '1; oe_term = '1; pl_val = '0; pin_in = '0;
        cfg_comb = 4'b1100; cfg_pol = 4'b1010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cyc("R10");                         // reset state: registers at 0
        rst_n = 1;

        // Random sum, enable and pin input, with the configuration fixed.
        for (int k = 0; k < 40; k++) begin
            sum_term = LANES'($urandom); oe_term = LANES'($urandom);
            pin_in   = LANES'($urandom);
            cyc("R2 R3 R4 R8 R9");
        end

        // Mode and polarity sweep while running.
        for (int k = 0; k < 40; k++) begin
            cfg_comb = LANES'($urandom); cfg_pol = LANES'($urandom);
            sum_term = LANES'($urandom); oe_term = LANES'($urandom);
            pin_in   = LANES'($urandom);
            cyc("R1 R7");
        end

        // Registered lanes, driver on or off, with pin_in toggling.
        cfg_comb = 4'b0000; cfg_pol = 4'b0101; sum_term = '1;
        for (int k = 0; k < 8; k++) begin
            pin_in = LANES'($urandom); oe_term = LANES'($urandom);
            cyc("R8");
        end

        // Clear in mid-cycle with set, preload and sum also active.
        ar_term = 1; sp_term = 1; pl_en = 1; pl_val = '1;
        cyc("R5 R7");
        cyc("R5");
        ar_term = 0; sp_term = 0; pl_en = 0; sum_term = '0;
        cyc("R5");

        // Set beats preload and capture.
        sp_term = 1; pl_en = 1; pl_val = '0; sum_term = '0;
        cyc("R6");
        sp_term = 0; pl_en = 0; sum_term = '1;
        cyc("R6 R7");

        // Preload beats capture.
        pl_en = 1; pl_val = 4'b0101; sum_term = 4'b1010;
        cyc("R11");
        pl_val = 4'b1010; sum_term = 4'b0101;
        cyc("R11");
        pl_en = 0;
        cyc("R11");

        // Synchronous reset: no change before the edge, then cleared.
        sum_term = '1;
        cyc("R3");
        cyc("R3");
        rst_n = 0;
        cyc("R10");
        cyc("R10");
        rst_n = 1;

        // Combinatorial lanes with the driver off read the external pin.
        cfg_comb = '1; oe_term = '0;
        for (int k = 0; k < 8; k++) begin
            pin_in = LANES'($urandom); sum_term = LANES'($urandom);
            cfg_pol = LANES'($urandom);
            cyc("R9");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule